// File: doc/BRIEF.md
# Serial Programmer Command Interpreter

This block sits between a host byte stream and a target device's serial programming port. The host sends one-letter commands, some followed by argument bytes. The block keeps a 16-bit target address and a device-type code. It turns each programming command into one or more four-byte instructions, and it passes each instruction one byte at a time to an external SPI byte engine. The engine returns one byte for every byte sent. The block then replies to the host with a carriage return, a data byte or an error mark.

All data enters and leaves on valid/ready streams. A byte moves only in a cycle where both valid and ready are high. Once a sender raises valid, it holds valid and the data unchanged until the transfer happens. The block accepts host bytes only while it is waiting for a command or its arguments. It therefore stalls the host for as long as an instruction, a write wait or a full reply slot is pending. The write wait belongs to an external delay counter: the block raises `wait_req` and holds it until `wait_done` arrives.

Top module: `prog_cmd_engine`

## Requirements
- R1: After reset, `tx_valid`, `spi_req_valid` and `wait_req` are low, `pins_en` is low and `tgt_reset` is high.
- R2: When an ESC byte (0x1B) arrives in the command position, it is dropped with no reply and no instruction, and the next byte is decoded as a command.
- R3: 'a' (0x61) replies 'Y' (0x59). 'p' (0x70) replies 'S' (0x53). 'x' (0x78) and 'y' (0x79) reply CR (0x0D) and have no other effect. 'T' (0x54) takes one byte, stores it as the device code and replies CR. None of these sends an instruction.
- R4: The block replies '?' (0x3F) and sends no instruction in two cases: an undefined command byte, or any other command while the device code is not one of 0x13 0x20 0x28 0x30 0x34 0x38 0x41 0x42 0x48 0x4C 0x55 0x56 0x60 0x64 0x65 0x68 0x6C.
- R5: 'P' (0x50) does three things: it sets `pins_en` high, it drives `tgt_reset` low, and it sends AC 53 00 00 before replying CR. 'L' (0x4C) does three things: it sets `pins_en` low, it drives `tgt_reset` high, and it replies CR with no instruction.
- R6: 'A' (0x41) takes the high address byte and then the low address byte, and replies CR. 'R' (0x52) sends 28 ah al 00 and then 20 ah al 00. It returns the byte read during the fourth byte of each instruction, in that order, and then adds one to the address. The carry passes from the low byte into the high byte.
- R7: 'c' (0x63) and 'C' (0x43) take one data byte and send 40 ah al dd or 48 ah al dd. Only 'C' increments the address. For a paged device code (0x41 0x42 0x60 0x64 0x65), CR follows at once. For any other device code, a write wait comes before the CR.
- R8: 'D' (0x44) takes one byte, sends C0 ah al dd, waits, and replies CR. 'd' (0x64) sends A0 ah al 00 and returns the byte read. Both commands increment the address.
- R9: Each of the following sends its instruction, waits, and replies CR. 'm' (0x6D) sends 4C ah al 00. 'e' (0x65) sends AC 80 04 00. 'l' (0x6C) takes one byte and sends AC, (byte AND 06) OR E0, 00, 00.
- R10: 's' (0x73) sends 30 00 n 00 for n = 2, then 1, then 0. It returns the three bytes read, in that order.
- R11: ':' (0x3A) takes three bytes and sends them followed by 00. '.' (0x2E) takes four bytes and sends them. Both return the byte read during the fourth byte, wait, and reply CR.
- R12: Flow control works as follows:
  - `tx_data` stays stable while `tx_valid` is high and `tx_ready` is low.
  - The request byte stays stable while `spi_req_valid` is high and `spi_req_ready` is low.
  - `wait_req` stays high until `wait_done`.
  - `rx_ready` is low while an instruction or a wait is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Host byte offered |
| rx_data | input | 8 | Host byte |
| rx_ready | output | 1 | Block takes the host byte |
| tx_valid | output | 1 | Reply byte offered |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Host side takes the reply byte |
| spi_req_valid | output | 1 | Instruction byte offered to the SPI engine |
| spi_req_byte | output | 8 | Instruction byte |
| spi_req_ready | input | 1 | SPI engine takes the byte |
| spi_rsp_valid | input | 1 | Byte read back by the SPI engine |
| spi_rsp_byte | input | 8 | Read-back byte |
| spi_rsp_ready | output | 1 | Block takes the read-back byte |
| wait_req | output | 1 | Write wait in progress |
| wait_done | input | 1 | Delay counter finished |
| pins_en | output | 1 | Programming pins driven |
| tgt_reset | output | 1 | Target reset line level |

## Verification
The assertions check the flow-control rules of R12 on every cycle: stable reply and request bytes under back-pressure, a held wait request, and no host intake during an instruction or a wait. They also check that programming entry lowers the target reset in the same cycle. The rest can only be shown by the bench's scenarios. That covers the opcode bytes of each instruction, the order of returned bytes, which commands increment the address and the carry across the byte boundary. It also covers the error path for unknown codes and the skipped wait for paged devices. The scoreboard compares these against queues filled by the driver, while the SPI engine, reply sink and delay counter apply random back-pressure.

// File: rtl/pcmd_pkg.sv
package pcmd_pkg;

  localparam int BYTE_W  = 8;
  localparam int FRAME_B = 4;
  localparam int ARG_MAX = 4;
  localparam int ARG_CW  = $clog2(ARG_MAX + 1);
  localparam int N_KNOWN = 17;
  localparam int N_PAGED = 5;

  localparam logic [7:0] CH_ESC = 8'h1B;
  localparam logic [7:0] CH_CR  = 8'h0D;
  localparam logic [7:0] CH_ERR = 8'h3F;
  localparam logic [7:0] CH_YES = 8'h59;
  localparam logic [7:0] CH_SER = 8'h53;

  localparam logic [7:0] KNOWN_CODES [N_KNOWN] = '{
    8'h13, 8'h20, 8'h28, 8'h30, 8'h34, 8'h38, 8'h41, 8'h42, 8'h48,
    8'h4C, 8'h55, 8'h56, 8'h60, 8'h64, 8'h65, 8'h68, 8'h6C};
  localparam logic [7:0] PAGED_CODES [N_PAGED] = '{
    8'h41, 8'h42, 8'h60, 8'h64, 8'h65};

  typedef enum logic [2:0] {
    ST_CMD, ST_ARG, ST_EXEC, ST_LAUNCH, ST_SPI, ST_POST, ST_DLY, ST_REPLY
  } state_t;

  typedef enum logic [4:0] {
    OP_NONE, OP_DEV, OP_AUTOINC, OP_PTYPE, OP_LED, OP_ADDR, OP_ENTER,
    OP_LEAVE, OP_RDPROG, OP_WRLO, OP_WRHI, OP_WRDATA, OP_RDDATA, OP_PAGE,
    OP_ERASE, OP_LOCK, OP_SIG, OP_UNI3, OP_UNI4
  } op_t;

  function automatic op_t decode_op(logic [7:0] b);
    case (b)
      8'h54: return OP_DEV;
      8'h61: return OP_AUTOINC;
      8'h70: return OP_PTYPE;
      8'h78, 8'h79: return OP_LED;
      8'h41: return OP_ADDR;
      8'h50: return OP_ENTER;
      8'h4C: return OP_LEAVE;
      8'h52: return OP_RDPROG;
      8'h63: return OP_WRLO;
      8'h43: return OP_WRHI;
      8'h44: return OP_WRDATA;
      8'h64: return OP_RDDATA;
      8'h6D: return OP_PAGE;
      8'h65: return OP_ERASE;
      8'h6C: return OP_LOCK;
      8'h73: return OP_SIG;
      8'h3A: return OP_UNI3;
      8'h2E: return OP_UNI4;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic [ARG_CW-1:0] op_args(op_t o);
    case (o)
      OP_ADDR: return ARG_CW'(2);
      OP_DEV, OP_WRLO, OP_WRHI, OP_WRDATA, OP_LOCK: return ARG_CW'(1);
      OP_UNI3: return ARG_CW'(3);
      OP_UNI4: return ARG_CW'(4);
      default: return ARG_CW'(0);
    endcase
  endfunction

  function automatic logic op_needs_dev(op_t o);
    return !(o inside {OP_NONE, OP_DEV, OP_AUTOINC, OP_PTYPE, OP_LED});
  endfunction

  function automatic logic code_known(logic [7:0] c);
    logic hit = 1'b0;
    for (int i = 0; i < N_KNOWN; i++) hit |= (c == KNOWN_CODES[i]);
    return hit;
  endfunction

  function automatic logic code_paged(logic [7:0] c);
    logic hit = 1'b0;
    for (int i = 0; i < N_PAGED; i++) hit |= (c == PAGED_CODES[i]);
    return hit;
  endfunction

  // Four-byte instruction, first byte on the transmit side in the top byte.
  function automatic logic [FRAME_B*BYTE_W-1:0] build_frame(
      op_t o, logic [1:0] step, logic [7:0] ah, logic [7:0] al,
      logic [7:0] a0, logic [7:0] a1, logic [7:0] a2, logic [7:0] a3);
    case (o)
      OP_ENTER:  return {8'hAC, 8'h53, 8'h00, 8'h00};
      OP_RDPROG: return {(step == 2'd0) ? 8'h28 : 8'h20, ah, al, 8'h00};
      OP_WRLO:   return {8'h40, ah, al, a0};
      OP_WRHI:   return {8'h48, ah, al, a0};
      OP_WRDATA: return {8'hC0, ah, al, a0};
      OP_RDDATA: return {8'hA0, ah, al, 8'h00};
      OP_PAGE:   return {8'h4C, ah, al, 8'h00};
      OP_ERASE:  return {8'hAC, 8'h80, 8'h04, 8'h00};
      OP_LOCK:   return {8'hAC, (a0 & 8'h06) | 8'hE0, 8'h00, 8'h00};
      OP_SIG:    return {8'h30, 8'h00, 8'h02 - {6'd0, step}, 8'h00};
      OP_UNI3, OP_UNI4: return {a0, a1, a2, a3};
      default:   return '0;
    endcase
  endfunction

endpackage

// File: rtl/pcmd_addr_reg.sv
module pcmd_addr_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (inc)  addr <= addr + ADDR_W'(1);
  end
endmodule

// File: rtl/pcmd_spi_seq.sv
module pcmd_spi_seq #(
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NB*BW-1:0] frame,
  output logic           done,
  output logic [BW-1:0]  last_rd,
  output logic           req_valid,
  output logic [BW-1:0]  req_byte,
  input  logic           req_ready,
  input  logic           rsp_valid,
  input  logic [BW-1:0]  rsp_byte,
  output logic           rsp_ready
);
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic              active;
  logic              awaiting;
  logic [IW-1:0]     idx;
  logic [NB*BW-1:0]  shreg;

  assign req_valid = active && !awaiting;
  assign rsp_ready = active && awaiting;
  assign req_byte  = shreg[NB*BW-1 -: BW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      awaiting <= 1'b0;
      idx      <= '0;
      shreg    <= '0;
      done     <= 1'b0;
      last_rd  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active   <= 1'b1;
        awaiting <= 1'b0;
        idx      <= '0;
        shreg    <= frame;
      end else if (req_valid && req_ready) begin
        awaiting <= 1'b1;
      end else if (rsp_valid && rsp_ready) begin
        awaiting <= 1'b0;
        shreg    <= shreg << BW;
        if (idx == IW'(NB - 1)) begin
          active  <= 1'b0;
          done    <= 1'b1;
          last_rd <= rsp_byte;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pcmd_tx_slot.sv
module pcmd_tx_slot #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [BW-1:0] din,
  output logic          full,
  output logic          tx_valid,
  output logic [BW-1:0] tx_data,
  input  logic          tx_ready
);
  assign tx_valid = full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      tx_data <= '0;
    end else if (push && !full) begin
      full    <= 1'b1;
      tx_data <= din;
    end else if (full && tx_ready) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/prog_cmd_engine.sv
module prog_cmd_engine
  import pcmd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       spi_req_valid,
  output logic [7:0] spi_req_byte,
  input  logic       spi_req_ready,
  input  logic       spi_rsp_valid,
  input  logic [7:0] spi_rsp_byte,
  output logic       spi_rsp_ready,
  output logic       wait_req,
  input  logic       wait_done,
  output logic       pins_en,
  output logic       tgt_reset
);
  localparam int HI_LSB = ADDR_W - BYTE_W;

  state_t            state;
  op_t               op;
  logic [7:0]        args [ARG_MAX];
  logic [ARG_CW-1:0] arg_cnt, arg_need;
  logic [7:0]        dev_code;
  logic [1:0]        step;
  logic [7:0]        reply;

  logic [ADDR_W-1:0] addr;
  logic              addr_load, addr_inc;
  logic              seq_start, seq_done;
  logic [7:0]        seq_rd;
  logic [FRAME_B*BYTE_W-1:0] frame;
  logic              tx_push, tx_full;
  logic [7:0]        tx_din;
  logic              rx_fire, exec_ok, post_push, post_go, dev_paged;

  assign rx_ready  = (state == ST_CMD) || (state == ST_ARG);
  assign rx_fire   = rx_valid && rx_ready;
  assign wait_req  = (state == ST_DLY);
  assign seq_start = (state == ST_LAUNCH);
  assign exec_ok   = (op != OP_NONE) && (!op_needs_dev(op) || code_known(dev_code));
  assign dev_paged = code_paged(dev_code);
  assign post_push = op inside {OP_RDPROG, OP_RDDATA, OP_SIG, OP_UNI3, OP_UNI4};
  assign post_go   = !(post_push && tx_full);
  assign addr_load = (state == ST_EXEC) && exec_ok && (op == OP_ADDR);
  assign addr_inc  = (state == ST_POST) && post_go &&
                     ((op inside {OP_WRHI, OP_WRDATA, OP_RDDATA}) ||
                      (op == OP_RDPROG && step == 2'd1));
  assign tx_push   = !tx_full && ((state == ST_REPLY) || (state == ST_POST && post_push));
  assign tx_din    = (state == ST_REPLY) ? reply : seq_rd;
  assign frame     = build_frame(op, step, addr[ADDR_W-1 -: BYTE_W], addr[BYTE_W-1:0],
                                 args[0], args[1], args[2], args[3]);

  pcmd_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load),
    .load_val(ADDR_W'({args[0], args[1]})), .inc(addr_inc), .addr(addr)
  );

  pcmd_spi_seq #(.NB(FRAME_B), .BW(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .frame(frame),
    .done(seq_done), .last_rd(seq_rd),
    .req_valid(spi_req_valid), .req_byte(spi_req_byte), .req_ready(spi_req_ready),
    .rsp_valid(spi_rsp_valid), .rsp_byte(spi_rsp_byte), .rsp_ready(spi_rsp_ready)
  );

  pcmd_tx_slot #(.BW(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_din), .full(tx_full),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_CMD;
      op        <= OP_NONE;
      arg_cnt   <= '0;
      arg_need  <= '0;
      dev_code  <= '0;
      step      <= '0;
      reply     <= CH_CR;
      pins_en   <= 1'b0;
      tgt_reset <= 1'b1;
      for (int i = 0; i < ARG_MAX; i++) args[i] <= '0;
    end else begin
      case (state)
        ST_CMD: if (rx_fire && rx_data != CH_ESC) begin
          op       <= decode_op(rx_data);
          arg_need <= op_args(decode_op(rx_data));
          arg_cnt  <= '0;
          step     <= '0;
          for (int i = 0; i < ARG_MAX; i++) args[i] <= '0;
          state    <= (op_args(decode_op(rx_data)) == '0) ? ST_EXEC : ST_ARG;
        end
        ST_ARG: if (rx_fire) begin
          for (int i = 0; i < ARG_MAX; i++)
            if (arg_cnt == ARG_CW'(i)) args[i] <= rx_data;
          arg_cnt <= arg_cnt + ARG_CW'(1);
          if (arg_cnt + ARG_CW'(1) == arg_need) state <= ST_EXEC;
        end
        ST_EXEC: begin
          reply <= CH_CR;
          state <= ST_REPLY;
          if (!exec_ok) begin
            reply <= CH_ERR;
          end else begin
            case (op)
              OP_DEV:     dev_code <= args[0];
              OP_AUTOINC: reply <= CH_YES;
              OP_PTYPE:   reply <= CH_SER;
              OP_LED, OP_ADDR: ;
              OP_LEAVE: begin
                pins_en   <= 1'b0;
                tgt_reset <= 1'b1;
              end
              OP_ENTER: begin
                pins_en   <= 1'b1;
                tgt_reset <= 1'b0;
                state     <= ST_LAUNCH;
              end
              default: state <= ST_LAUNCH;
            endcase
          end
        end
        ST_LAUNCH: state <= ST_SPI;
        ST_SPI: if (seq_done) state <= ST_POST;
        ST_POST: if (post_go) begin
          reply <= CH_CR;
          case (op)
            OP_RDPROG: if (step == 2'd0) begin
              step  <= 2'd1;
              state <= ST_LAUNCH;
            end else state <= ST_CMD;
            OP_SIG: if (step != 2'd2) begin
              step  <= step + 2'd1;
              state <= ST_LAUNCH;
            end else state <= ST_CMD;
            OP_RDDATA: state <= ST_CMD;
            OP_WRLO, OP_WRHI: state <= dev_paged ? ST_REPLY : ST_DLY;
            OP_ENTER: state <= ST_REPLY;
            default: state <= ST_DLY;
          endcase
        end
        ST_DLY: if (wait_done) state <= ST_REPLY;
        ST_REPLY: if (!tx_full) state <= ST_CMD;
        default: state <= ST_CMD;
      endcase
    end
  end
endmodule

// File: rtl/pcmd_checker.sv
module pcmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       spi_req_valid,
  input logic [7:0] spi_req_byte,
  input logic       spi_req_ready,
  input logic       wait_req,
  input logic       wait_done,
  input logic       pins_en,
  input logic       tgt_reset
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R12
  AST_SPI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req_valid && !spi_req_ready |=> spi_req_valid && $stable(spi_req_byte)); // R12
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req && !wait_done |=> wait_req); // R12
  AST_NO_RX_DURING_SPI: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req_valid |-> !rx_ready); // R12
  AST_NO_RX_DURING_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |-> !rx_ready); // R12
  AST_ENTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_en) |-> $fell(tgt_reset)); // R5
endmodule

bind prog_cmd_engine pcmd_checker u_pcmd_checker (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_ready(tx_ready), .spi_req_valid(spi_req_valid),
  .spi_req_byte(spi_req_byte), .spi_req_ready(spi_req_ready),
  .wait_req(wait_req), .wait_done(wait_done), .pins_en(pins_en),
  .tgt_reset(tgt_reset)
);

// File: tb/test_prog_cmd_engine.sv
module test_prog_cmd_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;
  logic       spi_req_valid;
  logic [7:0] spi_req_byte;
  logic       spi_req_ready = 1'b0;
  logic       spi_rsp_valid = 1'b0;
  logic [7:0] spi_rsp_byte = '0;
  logic       spi_rsp_ready;
  logic       wait_req;
  logic       wait_done = 1'b0;
  logic       pins_en;
  logic       tgt_reset;

  prog_cmd_engine i_prog_cmd_engine (.*);

  logic [7:0] exp_tx[$];
  string      exp_tx_tag[$];
  logic [7:0] exp_spi[$];
  string      exp_spi_tag[$];
  int n_chk = 0;
  int n_err = 0;
  int waits_seen = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic exp_reply(logic [7:0] b, string tag);
    exp_tx.push_back(b);
    exp_tx_tag.push_back(tag);
  endtask

  task automatic exp_frame(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                           logic [7:0] b3, string tag);
    exp_spi.push_back(b0); exp_spi.push_back(b1);
    exp_spi.push_back(b2); exp_spi.push_back(b3);
    repeat (4) exp_spi_tag.push_back(tag);
  endtask

  task automatic settle();
    while (exp_tx.size() != 0 || exp_spi.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic waits_check(int base, int n, string tag);
    chk(waits_seen - base == n, tag, "write waits", waits_seen - base, n);
  endtask

  // Scoreboard monitor and peripheral models, all on the falling edge.
  logic [7:0] lfsr = 8'h5B;
  logic [7:0] last_req = '0;
  logic       rsp_fired = 1'b0;
  int         rsp_due = -1;
  int         wcnt = 0;
  always @(negedge clk) begin
    if (rsp_fired) begin spi_rsp_valid = 1'b0; rsp_fired = 1'b0; end
    if (wait_done) wait_done = 1'b0;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready      = lfsr[0] | lfsr[3];
    spi_req_ready = lfsr[1] | lfsr[6];
    if (rsp_due > 0) rsp_due--;
    else if (rsp_due == 0) begin spi_rsp_valid = 1'b1; rsp_due = -1; end
    if (rst_n && wait_req) begin
      wcnt++;
      if (wcnt == 3) begin wait_done = 1'b1; wcnt = 0; waits_seen++; end
    end
    if (rst_n && spi_rsp_valid && spi_rsp_ready) rsp_fired = 1'b1;
    if (rst_n && spi_req_valid && spi_req_ready) begin
      if (exp_spi.size() == 0) begin
        chk(1'b0, "R4", "unexpected instruction byte", spi_req_byte, 0);
      end else begin
        chk(spi_req_byte == exp_spi[0], exp_spi_tag[0], "instruction byte",
            spi_req_byte, exp_spi[0]);
        void'(exp_spi.pop_front());
        void'(exp_spi_tag.pop_front());
      end
      spi_rsp_byte = last_req + 8'h11;
      last_req = spi_req_byte;
      rsp_due = 2;
    end
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_tx.size() == 0) begin
        chk(1'b0, "R2", "unexpected reply byte", tx_data, 0);
      end else begin
        chk(tx_data == exp_tx[0], exp_tx_tag[0], "reply byte", tx_data, exp_tx[0]);
        void'(exp_tx.pop_front());
        void'(exp_tx_tag.pop_front());
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int wb;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!tx_valid && !spi_req_valid && !wait_req, "R1", "outputs idle",
        {tx_valid, spi_req_valid, wait_req}, 0);
    chk(!pins_en && tgt_reset, "R1", "pins released", {pins_en, tgt_reset}, 1);
    rst_n = 1'b1;

    // R2 and R3: ESC dropped, fixed replies
    send(8'h1B); exp_reply(8'h59, "R2"); send(8'h61); settle();
    exp_reply(8'h53, "R3"); send(8'h70);
    exp_reply(8'h0D, "R3"); send(8'h78);
    exp_reply(8'h0D, "R3"); send(8'h79); settle();
    chk(!pins_en && tgt_reset, "R3", "LED command has no effect", {pins_en, tgt_reset}, 1);

    // R4: no device selected, then unsupported device code
    exp_reply(8'h3F, "R4"); send(8'h65); settle();
    exp_reply(8'h0D, "R3"); send(8'h54); send(8'h99);
    exp_reply(8'h3F, "R4"); send(8'h50); settle();
    chk(!pins_en, "R4", "enter refused", pins_en, 0);

    // R5: enter programming mode with a byte-mode device
    exp_reply(8'h0D, "R3"); send(8'h54); send(8'h38);
    exp_frame(8'hAC, 8'h53, 8'h00, 8'h00, "R5"); exp_reply(8'h0D, "R5");
    send(8'h50); settle();
    chk(pins_en && !tgt_reset, "R5", "programming mode", {pins_en, tgt_reset}, 2);
    exp_reply(8'h3F, "R4"); send(8'h51); settle();

    // R6: address load, program read, carry into the high byte
    exp_reply(8'h0D, "R6"); send(8'h41); send(8'h12); send(8'hFF);
    exp_frame(8'h28, 8'h12, 8'hFF, 8'h00, "R6"); exp_reply(8'h10, "R6");
    exp_frame(8'h20, 8'h12, 8'hFF, 8'h00, "R6"); exp_reply(8'h10, "R6");
    send(8'h52);
    exp_frame(8'hA0, 8'h13, 8'h00, 8'h00, "R6"); exp_reply(8'h11, "R8");
    send(8'h64); settle();

    // R7: low write keeps address, high write increments, both wait
    wb = waits_seen;
    exp_frame(8'h40, 8'h13, 8'h01, 8'h5A, "R7"); exp_reply(8'h0D, "R7");
    send(8'h63); send(8'h5A);
    exp_frame(8'h48, 8'h13, 8'h01, 8'h7E, "R7"); exp_reply(8'h0D, "R7");
    send(8'h43); send(8'h7E); settle();
    waits_check(wb, 2, "R7");

    // R8: data write and read, both increment
    wb = waits_seen;
    exp_frame(8'hC0, 8'h13, 8'h02, 8'h33, "R8"); exp_reply(8'h0D, "R8");
    send(8'h44); send(8'h33);
    exp_frame(8'hA0, 8'h13, 8'h03, 8'h00, "R8"); exp_reply(8'h14, "R8");
    send(8'h64); settle();
    waits_check(wb, 1, "R8");

    // R9: page write, erase, lock bits
    wb = waits_seen;
    exp_frame(8'h4C, 8'h13, 8'h04, 8'h00, "R9"); exp_reply(8'h0D, "R9"); send(8'h6D);
    exp_frame(8'hAC, 8'h80, 8'h04, 8'h00, "R9"); exp_reply(8'h0D, "R9"); send(8'h65);
    exp_frame(8'hAC, 8'hE6, 8'h00, 8'h00, "R9"); exp_reply(8'h0D, "R9");
    send(8'h6C); send(8'hFF); settle();
    waits_check(wb, 3, "R9");

    // R10: signature bytes
    exp_frame(8'h30, 8'h00, 8'h02, 8'h00, "R10"); exp_reply(8'h13, "R10");
    exp_frame(8'h30, 8'h00, 8'h01, 8'h00, "R10"); exp_reply(8'h12, "R10");
    exp_frame(8'h30, 8'h00, 8'h00, 8'h00, "R10"); exp_reply(8'h11, "R10");
    send(8'h73); settle();

    // R11: universal instructions
    wb = waits_seen;
    exp_frame(8'h11, 8'h22, 8'h33, 8'h00, "R11"); exp_reply(8'h44, "R11"); exp_reply(8'h0D, "R11");
    send(8'h3A); send(8'h11); send(8'h22); send(8'h33);
    exp_frame(8'h01, 8'h02, 8'h03, 8'h04, "R11"); exp_reply(8'h14, "R11"); exp_reply(8'h0D, "R11");
    send(8'h2E); send(8'h01); send(8'h02); send(8'h03); send(8'h04); settle();
    waits_check(wb, 2, "R11");

    // R7: paged device skips the write wait, address unchanged by 'm'
    exp_reply(8'h0D, "R3"); send(8'h54); send(8'h64); settle();
    wb = waits_seen;
    exp_frame(8'h40, 8'h13, 8'h04, 8'h01, "R7"); exp_reply(8'h0D, "R7");
    send(8'h63); send(8'h01); settle();
    waits_check(wb, 0, "R7");

    // R5: leave programming mode
    exp_reply(8'h0D, "R5"); send(8'h4C); settle();
    chk(!pins_en && tgt_reset, "R5", "pins released", {pins_en, tgt_reset}, 1);
    chk(exp_tx.size() == 0 && exp_spi.size() == 0, "R12", "queues drained",
        exp_tx.size() + exp_spi.size(), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule